// File: doc/BRIEF.md
# Bit Permutation Unit: Generalized Reverse, OR-Combine and Shuffle

This block rearranges the bits of a 64-bit word with a row of butterfly stages. Each stage acts on groups of 1, 2, 4, 8, 16 or 32 bits, and one bit of the control amount turns each stage on or off. The same stage logic serves four operations. The generalized reverse swaps neighbouring groups. The OR-combine merges each group with its neighbour. The shuffle interleaves the two halves of a group. The unshuffle undoes the shuffle. A word flag limits any operation to the low 32 bits and sign-extends the 32-bit result to 64 bits.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream, one register later. A beat is taken when `in_valid` and `in_ready` are both high on a rising edge. A result is taken when `out_valid` and `out_ready` are both high. While a result is waiting and `out_ready` is low, the unit holds that result and drops `in_ready`, so back-pressure reaches the producer in the same cycle. With `out_ready` held high, the unit takes one beat per cycle.

Top module: `perm_unit`

## Requirements
- R1: With `in_op` = 0 (generalized reverse), every set bit k of the control swaps adjacent 2^k-bit groups, so output bit i equals input bit (i XOR ctrl). A control of zero passes the data through unchanged.
- R2: With `in_op` = 1 (OR-combine), every enabled stage ORs the swapped word into the running value, so output bit i is the OR of every input bit j for which (i XOR j) has no bit outside the control.
- R3: With `in_op` = 2 (shuffle), control bit k enables a stage that exchanges index bits k and k+1 of every bit position. The enabled stages run from the largest group size down to the smallest. A full control of 31 on 0x00000000FFFFFFFF gives 0x5555555555555555.
- R4: With `in_op` = 3 (unshuffle), the stages are the same as in shuffle but run from the smallest group size up to the largest, so that unshuffle(shuffle(x, c), c) = x for every c.
- R5: In 64-bit mode, reverse and OR-combine use `in_ctrl[5:0]`. Shuffle and unshuffle use only `in_ctrl[4:0]`, and `in_ctrl[5]` has no effect on them.
- R6: With `in_word` high, the unit operates on `in_data[31:0]` alone. Reverse and OR-combine use `in_ctrl[4:0]`, and shuffle and unshuffle use `in_ctrl[3:0]`. `in_data[63:32]` has no effect, and the result is the 32-bit outcome sign-extended from its bit 31.
- R7: A beat accepted on a rising edge appears with `out_valid` high after that edge. If no beat is accepted while the output stage is free, `out_valid` is low after the edge.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_data` hold their values.
- R9: During reset and after it, `out_valid` and `out_data` are zero until the first beat is accepted.
- R10: Applying the reverse twice with the same control returns the original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_data | input | 64 | Data word to permute |
| in_ctrl | input | 6 | Stage enable amount |
| in_op | input | 2 | 0 reverse, 1 OR-combine, 2 shuffle, 3 unshuffle |
| in_word | input | 1 | Operate on low 32 bits and sign-extend the result |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Permuted result |

## Verification
Every result is due exactly one rising edge after its beat is accepted. The bench drives a beat at a falling edge, lets one rising edge pass, and reads `out_valid` and `out_data` at the next falling edge. During a stall the bench checks the held result and the low `in_ready` at falling edges after each extra rising edge. The result of the second beat is read one edge after `out_ready` rises, because the waiting result leaves and the new beat enters on that same edge.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [1:0] {
    OP_GREV   = 2'd0,
    OP_GORC   = 2'd1,
    OP_SHFL   = 2'd2,
    OP_UNSHFL = 2'd3
  } perm_op_e;

  // Bits whose index has bit k clear: the lower member of each 2^k pair.
  function automatic logic [63:0] pair_low_mask(input int unsigned k);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction

  // Shuffle destination masks: index bits (k+1,k) equal to sel.
  function automatic logic [63:0] quad_mask(input int unsigned k, input int unsigned sel);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = ((i >> k) & 3) == sel;
    return m;
  endfunction

endpackage

// File: rtl/perm_swap_stage.sv
module perm_swap_stage #(
  parameter int W = 64,
  parameter int K = 0
) (
  input  logic [W-1:0] x,
  input  logic         en,
  input  logic         orc,
  output logic [W-1:0] y
);
  localparam int N = 1 << K;
  localparam logic [63:0] MASK64 = perm_pkg::pair_low_mask(K);
  localparam logic [W-1:0] LO = MASK64[W-1:0];

  logic [W-1:0] swapped;

  always_comb begin
    swapped = ((x & LO) << N) | ((x & ~LO) >> N);
    if (!en)      y = x;
    else if (orc) y = x | swapped;
    else          y = swapped;
  end

  always_comb begin
    if (en && !orc) AST_SWAP_KEEPS_ONES: assert ($countones(y) == $countones(x)); // R1
    if (en && orc)  AST_ORC_SUPERSET: assert ((y & x) == x); // R2
    if (!en)        AST_STAGE_BYPASS: assert (y == x); // R1
  end
endmodule

// File: rtl/perm_shuffle_stage.sv
module perm_shuffle_stage #(
  parameter int W = 64,
  parameter int K = 0
) (
  input  logic [W-1:0] x,
  input  logic         en,
  output logic [W-1:0] y
);
  localparam int N = 1 << K;
  localparam logic [63:0] UP64 = perm_pkg::quad_mask(K, 2);
  localparam logic [63:0] DN64 = perm_pkg::quad_mask(K, 1);
  localparam logic [W-1:0] UP = UP64[W-1:0];
  localparam logic [W-1:0] DN = DN64[W-1:0];

  always_comb begin
    if (en) y = (x & ~(UP | DN)) | ((x << N) & UP) | ((x >> N) & DN);
    else    y = x;
  end

  always_comb begin
    AST_SHUFFLE_KEEPS_ONES: assert ($countones(y) == $countones(x)); // R3
  end
endmodule

// File: rtl/perm_core.sv
module perm_core #(
  parameter int W = 64,
  localparam int LOG = $clog2(W),
  localparam int SHN = LOG - 1
) (
  input  logic [W-1:0]     x,
  input  logic [LOG-1:0]   ctrl,
  input  perm_pkg::perm_op_e op,
  output logic [W-1:0]     y
);
  import perm_pkg::*;

  logic [W-1:0] bfly [0:LOG];
  logic [W-1:0] zip  [0:SHN];
  logic [W-1:0] unz  [0:SHN];
  logic         orc;

  assign orc     = (op == OP_GORC);
  assign bfly[0] = x;
  assign zip[0]  = x;
  assign unz[0]  = x;

  for (genvar k = 0; k < LOG; k++) begin : g_swap
    perm_swap_stage #(.W(W), .K(k)) u_stage (
      .x(bfly[k]), .en(ctrl[k]), .orc(orc), .y(bfly[k+1])
    );
  end

  // Shuffle: largest group first.
  for (genvar j = 0; j < SHN; j++) begin : g_zip
    perm_shuffle_stage #(.W(W), .K(SHN-1-j)) u_stage (
      .x(zip[j]), .en(ctrl[SHN-1-j]), .y(zip[j+1])
    );
  end

  // Unshuffle: smallest group first.
  for (genvar j = 0; j < SHN; j++) begin : g_unz
    perm_shuffle_stage #(.W(W), .K(j)) u_stage (
      .x(unz[j]), .en(ctrl[j]), .y(unz[j+1])
    );
  end

  always_comb begin
    unique case (op)
      OP_SHFL:   y = zip[SHN];
      OP_UNSHFL: y = unz[SHN];
      default:   y = bfly[LOG];
    endcase
  end
endmodule

// File: rtl/perm_unit.sv
module perm_unit #(
  parameter int DW = 64,
  localparam int HW = DW / 2,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_ctrl,
  input  logic [1:0]    in_op,
  input  logic          in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  import perm_pkg::*;

  perm_op_e      op;
  logic [DW-1:0] res_full;
  logic [HW-1:0] res_half;
  logic [DW-1:0] res;

  assign op = perm_op_e'(in_op);

  perm_core #(.W(DW)) u_full (
    .x(in_data), .ctrl(in_ctrl), .op(op), .y(res_full)
  );

  perm_core #(.W(HW)) u_half (
    .x(in_data[HW-1:0]), .ctrl(in_ctrl[CW-2:0]), .op(op), .y(res_half)
  );

  assign res      = in_word ? {{HW{res_half[HW-1]}}, res_half} : res_full;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= res;
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
endmodule

// File: tb/perm_unit_test.sv
`timescale 1ns/1ps
module perm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [5:0]  in_ctrl = '0;
  logic [1:0]  in_op = '0;
  logic        in_word = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  perm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_op(in_op), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // ---------------- reference model ----------------
  function automatic int swap_idx(int i, int k);
    int a = (i >> k) & 1;
    int b = (i >> (k + 1)) & 1;
    int r = i & ~(3 << k);
    return r | (a << (k + 1)) | (b << k);
  endfunction

  function automatic logic [63:0] ref_op(logic [63:0] x, int c, int op, bit word);
    int w = word ? 32 : 64;
    int nst = word ? 4 : 5;
    logic [63:0] r = '0;
    logic [63:0] t;
    if (op == 0) begin
      for (int i = 0; i < w; i++) r[i] = x[i ^ (c & (w - 1))];
    end else if (op == 1) begin
      for (int i = 0; i < w; i++)
        for (int j = 0; j < w; j++)
          if ((((i ^ j) & ~c) & (w - 1)) == 0) r[i] = r[i] | x[j];
    end else begin
      r = x;
      for (int s = 0; s < nst; s++) begin
        int k = (op == 3) ? s : nst - 1 - s;
        if ((c >> k) & 1) begin
          t = r;
          for (int i = 0; i < w; i++) r[i] = t[swap_idx(i, k)];
        end
      end
    end
    if (word) r = {{32{r[31]}}, r[31:0]};
    else if (w == 64) r = r;
    return r;
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_beat(logic [63:0] x, int c, int op, bit word, output logic [63:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_data = x; in_ctrl = c[5:0]; in_op = op[1:0]; in_word = word;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 out_valid", {63'd0, out_valid}, 64'd1);
    r = out_data;
  endtask

  task automatic op_check(string req, logic [63:0] x, int c, int op, bit word);
    logic [63:0] r;
    run_beat(x, c, op, word, r);
    chk(req, r, ref_op(x, c, op, word));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R9 out_data after reset", out_data, 64'd0);
  endtask

  task automatic t_grev();
    logic [63:0] r;
    run_beat(64'h1, 63, 0, 1'b0, r);
    chk("R1 full reverse", r, 64'h8000_0000_0000_0000);
    run_beat(64'h0123_4567_89AB_CDEF, 0, 0, 1'b0, r);
    chk("R1 zero ctrl passes", r, 64'h0123_4567_89AB_CDEF);
    for (int c = 1; c < 64; c += 5) op_check("R1 grev", 64'h0123_4567_89AB_CDEF, c, 0, 1'b0);
    op_check("R1 grev", 64'hF00D_0000_BEEF_0001, 24, 0, 1'b0);
  endtask

  task automatic t_gorc();
    logic [63:0] r;
    run_beat(64'h100, 7, 1, 1'b0, r);
    chk("R2 gorc byte fill", r, 64'hFF00);
    for (int c = 1; c < 64; c += 7) op_check("R2 gorc", 64'h8000_0040_0002_1000, c, 1, 1'b0);
  endtask

  task automatic t_shfl();
    logic [63:0] r;
    run_beat(64'h0000_0000_FFFF_FFFF, 31, 2, 1'b0, r);
    chk("R3 zip halves", r, 64'h5555_5555_5555_5555);
    for (int c = 1; c < 32; c += 3) op_check("R3 shfl", 64'h0123_4567_89AB_CDEF, c, 2, 1'b0);
    for (int c = 1; c < 32; c += 3) op_check("R4 unshfl", 64'hDEAD_BEEF_0F1E_2D3C, c, 3, 1'b0);
  endtask

  task automatic t_round_trip();
    logic [63:0] a, b;
    for (int c = 0; c < 32; c++) begin
      run_beat(64'hC3A5_1234_9876_0FF0, c, 2, 1'b0, a);
      run_beat(a, c, 3, 1'b0, b);
      chk("R4 unshfl(shfl)", b, 64'hC3A5_1234_9876_0FF0);
    end
  endtask

  task automatic t_grev_inverse();
    logic [63:0] a, b;
    for (int c = 0; c < 64; c += 9) begin
      run_beat(64'h0F0E_0D0C_0B0A_0908, c, 0, 1'b0, a);
      run_beat(a, c, 0, 1'b0, b);
      chk("R10 grev twice", b, 64'h0F0E_0D0C_0B0A_0908);
    end
  endtask

  task automatic t_ctrl_high();
    logic [63:0] a, b;
    run_beat(64'h1357_9BDF_0246_8ACE, 5'h13, 2, 1'b0, a);
    run_beat(64'h1357_9BDF_0246_8ACE, 6'h33, 2, 1'b0, b);
    chk("R5 ctrl[5] ignored by shfl", b, a);
    run_beat(64'h1357_9BDF_0246_8ACE, 6'h2A, 3, 1'b0, b);
    chk("R5 ctrl[5] ignored by unshfl", b, ref_op(64'h1357_9BDF_0246_8ACE, 6'h0A, 3, 1'b0));
  endtask

  task automatic t_word();
    logic [63:0] a, b;
    run_beat(64'h1, 31, 0, 1'b1, a);
    chk("R6 word reverse sign-extends", a, 64'hFFFF_FFFF_8000_0000);
    run_beat(64'hFFFF_FFFF_0000_0001, 31, 0, 1'b1, b);
    chk("R6 upper data ignored", b, a);
    run_beat(64'h0000_0000_0000_FFFF, 6'h2F, 2, 1'b1, a);
    chk("R6 word shfl ctrl[3:0] only", a, 64'h0000_0000_5555_5555);
    op_check("R6 word gorc", 64'hABCD_0000_0001_0000, 6'h3F, 1, 1'b1);
    op_check("R6 word unshfl", 64'h1234_5678_9ABC_DEF0, 6'h35, 3, 1'b1);
  endtask

  task automatic t_backpressure();
    logic [63:0] ea, eb;
    ea = ref_op(64'h1, 63, 0, 1'b0);
    eb = ref_op(64'h100, 7, 1, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 64'h1; in_ctrl = 6'd63; in_op = 2'd0; in_word = 1'b0;
    @(negedge clk);
    chk("R7 beat A out", out_data, ea);
    in_data = 64'h100; in_ctrl = 6'd7; in_op = 2'd1;
    for (int i = 0; i < 3; i++) begin
      chk("R8 in_ready low", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
      chk("R8 out_valid held", {63'd0, out_valid}, 64'd1);
      chk("R8 out_data held", out_data, ea);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 beat B after release", out_data, eb);
    @(negedge clk);
    chk("R7 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_grev();
    t_gorc();
    t_shfl();
    t_round_trip();
    t_grev_inverse();
    t_ctrl_high();
    t_word();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule